// File: doc/BRIEF.md
# CAN Standard-Frame Receive Error Detector

This block is the receive-side frame checker of a CAN controller working in standard (11-bit identifier) format. The bit-timing logic in front of it hands over one sampled bus level per bit time. Level 1 means recessive and level 0 means dominant. Each level arrives as a single-cycle transfer on a valid/ready input. The block follows the frame field by field. It removes stuff bits and flags stuffing violations. It checks the fixed-level bits at the tail of the frame and runs the 15-bit CAN CRC over the destuffed stream.

The outputs are single-cycle event pulses for stuff, form and CRC errors, and a frame-valid pulse. A store-enable pulse qualifies the received data for the buffers. A level output asks the transmit path to force the ACK slot dominant. The identifier acceptance filter only gates the store-enable output. It never suppresses the acknowledge.

The input stream never sees back-pressure: `bit_ready` is held high, and every cycle with `bit_valid` high transfers exactly one bus level. An event pulse appears in the clock cycle after the transfer that caused it.

Top module: `can_rx_errdet`

## Requirements
- R1: A bus level is consumed only in a cycle where `bit_valid` is high, and `bit_ready` is always high. Cycles without `bit_valid` change no state, whatever `rx_bit` does. `rx_bit` = 1 is recessive and 0 is dominant.
- R2: While idle, a dominant level is taken as start of frame. The CRC register is cleared at that point and the frame fields are then tracked in order: 11 identifier bits MSB first, the remote-request bit, two reserved control bits, 4 length bits MSB first, the data, 15 CRC bits, the CRC delimiter, the ACK slot, the ACK delimiter and 7 end-of-frame bits.
- R3: From start of frame to the end of the CRC sequence, including a stuff bit that directly follows the last CRC bit, the bit after five equal levels is a stuff bit. A stuff bit is discarded and is not counted in any field.
- R4: When the bit in a stuff position has the same level as the five before it, `stuff_err` pulses for one cycle.
- R5: A dominant level in the CRC delimiter, the ACK delimiter or any of the first six end-of-frame bits pulses `form_err`. A dominant CRC delimiter reports only the form error.
- R6: A dominant level in the seventh (last) end-of-frame bit is not an error.
- R7: The CRC uses the generator 0x4599 over the destuffed bits from start of frame through the data, continued through the received CRC sequence. If the result is non-zero when a recessive CRC delimiter arrives, `crc_err` pulses.
- R8: `frame_ok` pulses once, after the sixth end-of-frame bit, when no error has occurred in the frame.
- R9: `ack_drive` rises after a recessive CRC delimiter with a zero CRC remainder and falls after the ACK slot bit. This happens whatever the acceptance filter decides.
- R10: `store_en` pulses together with `frame_ok` only when ((identifier XOR `flt_id`) AND `flt_mask`) is zero. A mask bit of 1 means that identifier bit is compared.
- R11: After any error the block ignores dominant levels until it has seen one recessive level. Only then can a new start of frame be recognised.
- R12: At most one of `stuff_err`, `form_err`, `crc_err` and `frame_ok` is high in a cycle, and each is high only in the cycle after a transfer.
- R13: The data field holds min(length, 8) bytes when the remote-request bit is dominant, and no bytes when it is recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | One sampled bus level is offered this cycle |
| bit_ready | output | 1 | Always high; the block takes every offered level |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| flt_id | input | 11 | Acceptance filter identifier |
| flt_mask | input | 11 | Acceptance filter mask, 1 = bit compared |
| stuff_err | output | 1 | Stuffing violation pulse |
| form_err | output | 1 | Fixed-level bit violation pulse |
| crc_err | output | 1 | Non-zero CRC remainder pulse |
| ack_drive | output | 1 | Request to drive the ACK slot dominant |
| frame_ok | output | 1 | Receive frame valid pulse |
| store_en | output | 1 | Frame passes the acceptance filter, store data |

## Verification
The bench builds complete frames itself, with its own CRC and its own stuffer. It then damages them in one place at a time: a copied stuff bit, a flipped CRC bit, and a dominant level in each delimiter, in a middle end-of-frame bit and in the final end-of-frame bit. Some frames need a stuff bit right after the CRC, and these check whether the delimiter is found in the right place. A design that forgot to destuff there would report a false form error. A design that treats the last end-of-frame bit like the others would reject a good frame. Remote frames and a length code above eight test the data-length rule, where an off-by-one misaligns the CRC and gives a spurious CRC error. A frame that misses the filter must still be acknowledged. Dominant levels sent right after an error must not start a frame. Toggling the bus level while no transfer is offered must leave the next frame undisturbed.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RECOVER,
    ST_ARB,
    ST_CTRL,
    ST_DATA,
    ST_CRC,
    ST_CRC_DLM,
    ST_ACK_SLOT,
    ST_ACK_DLM,
    ST_EOF
  } rx_state_e;

endpackage

// File: rtl/can_destuff.sv
module can_destuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic in_valid,
  input  logic in_bit,
  output logic take,
  output logic skip,
  output logic viol,
  output logic due
);
  localparam int RW = $clog2(RUN + 1);

  logic [RW-1:0] run_q;
  logic          last_q;

  assign due  = (run_q == RW'(RUN));
  assign take = in_valid && active && !due;
  assign skip = in_valid && active && due && (in_bit != last_q);
  assign viol = in_valid && active && due && (in_bit == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (start) begin
      run_q  <= RW'(1);
      last_q <= 1'b0;
    end else if (in_valid && active) begin
      if (due || (in_bit != last_q)) begin
        run_q  <= RW'(1);
        last_q <= in_bit;
      end else begin
        run_q  <= run_q + RW'(1);
      end
    end
  end

endmodule

// File: rtl/can_crc_gen.sv
module can_crc_gen #(
  parameter int             W    = 15,
  parameter logic [W-1:0]   POLY = 15'h4599
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic shift,
  input  logic din,
  output logic zero
);
  logic [W-1:0] rem_q;
  logic         fb;

  assign fb   = din ^ rem_q[W-1];
  assign zero = (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (clear) begin
      rem_q <= '0;
    end else if (shift) begin
      rem_q <= {rem_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int ID_W = 11
) (
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] ref_id,
  input  logic [ID_W-1:0] mask,
  output logic            hit
);
  assign hit = (((id ^ ref_id) & mask) == '0);
endmodule

// File: rtl/can_rx_errdet.sv
module can_rx_errdet
  import can_rx_pkg::*;
#(
  parameter int             ID_W      = 11,
  parameter int             DLC_W     = 4,
  parameter int             MAX_BYTES = 8,
  parameter int             CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599,
  parameter int             STUFF_RUN = 5,
  parameter int             EOF_LEN   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  output logic            bit_ready,
  input  logic            rx_bit,
  input  logic [ID_W-1:0] flt_id,
  input  logic [ID_W-1:0] flt_mask,
  output logic            stuff_err,
  output logic            form_err,
  output logic            crc_err,
  output logic            ack_drive,
  output logic            frame_ok,
  output logic            store_en
);
  localparam int ARB_LEN  = ID_W + 1;
  localparam int CTRL_LEN = DLC_W + 2;
  localparam int MAX_BITS = MAX_BYTES * 8;
  localparam int CNT_TOP  = (MAX_BITS > CRC_W) ? MAX_BITS : CRC_W;
  localparam int CNT_W    = $clog2(CNT_TOP + 1);

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [ARB_LEN-1:0] arb_q;
  logic [CTRL_LEN-1:0] ctrl_q;
  logic [CNT_W-1:0]   data_bits_q;

  logic sof, in_field, stf_active, stf_take, stf_skip, stf_viol, stf_due;
  logic crc_zero, crc_shift, id_hit;
  logic [DLC_W-1:0] dlc_now;
  logic [CNT_W-1:0] nbytes, data_len;

  assign bit_ready = 1'b1;

  assign sof       = (state == ST_IDLE) && bit_valid && !rx_bit;
  assign in_field  = (state == ST_ARB) || (state == ST_CTRL) ||
                     (state == ST_DATA) || (state == ST_CRC);
  assign stf_active = in_field || ((state == ST_CRC_DLM) && stf_due);
  assign crc_shift = stf_take && in_field;

  can_destuff #(.RUN(STUFF_RUN)) u_destuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sof),
    .active   (stf_active),
    .in_valid (bit_valid),
    .in_bit   (rx_bit),
    .take     (stf_take),
    .skip     (stf_skip),
    .viol     (stf_viol),
    .due      (stf_due)
  );

  can_crc_gen #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (sof),
    .shift (crc_shift),
    .din   (rx_bit),
    .zero  (crc_zero)
  );

  can_id_filter #(.ID_W(ID_W)) u_filter (
    .id     (arb_q[ARB_LEN-1:1]),
    .ref_id (flt_id),
    .mask   (flt_mask),
    .hit    (id_hit)
  );

  // data length from the length code in its final bit, remote frames carry none
  always_comb begin
    dlc_now = {ctrl_q[DLC_W-2:0], rx_bit};
    if (int'(dlc_now) > MAX_BYTES) nbytes = CNT_W'(MAX_BYTES);
    else                           nbytes = CNT_W'(dlc_now);
    data_len = arb_q[0] ? '0 : {nbytes[CNT_W-4:0], 3'b000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      arb_q       <= '0;
      ctrl_q      <= '0;
      data_bits_q <= '0;
      stuff_err   <= 1'b0;
      form_err    <= 1'b0;
      crc_err     <= 1'b0;
      ack_drive   <= 1'b0;
      frame_ok    <= 1'b0;
      store_en    <= 1'b0;
    end else begin
      stuff_err <= 1'b0;
      form_err  <= 1'b0;
      crc_err   <= 1'b0;
      frame_ok  <= 1'b0;
      store_en  <= 1'b0;
      if (stf_viol) begin
        stuff_err <= 1'b1;
        state     <= ST_RECOVER;
      end else begin
        unique case (state)
          ST_IDLE: if (sof) begin
            state <= ST_ARB;
            cnt   <= '0;
          end
          ST_RECOVER: if (bit_valid && rx_bit) state <= ST_IDLE;
          ST_ARB: if (stf_take) begin
            arb_q <= {arb_q[ARB_LEN-2:0], rx_bit};
            if (cnt == CNT_W'(ARB_LEN - 1)) begin
              state <= ST_CTRL;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_CTRL: if (stf_take) begin
            ctrl_q <= {ctrl_q[CTRL_LEN-2:0], rx_bit};
            if (cnt == CNT_W'(CTRL_LEN - 1)) begin
              cnt         <= '0;
              data_bits_q <= data_len;
              state       <= (data_len == '0) ? ST_CRC : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: if (stf_take) begin
            if (cnt == data_bits_q - 1'b1) begin
              state <= ST_CRC;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_CRC: if (stf_take) begin
            if (cnt == CNT_W'(CRC_W - 1)) begin
              state <= ST_CRC_DLM;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_CRC_DLM: if (bit_valid && !stf_skip) begin
            if (!rx_bit) begin
              form_err <= 1'b1;
              state    <= ST_RECOVER;
            end else if (!crc_zero) begin
              crc_err <= 1'b1;
              state   <= ST_RECOVER;
            end else begin
              ack_drive <= 1'b1;
              state     <= ST_ACK_SLOT;
            end
          end
          ST_ACK_SLOT: if (bit_valid) begin
            ack_drive <= 1'b0;
            state     <= ST_ACK_DLM;
          end
          ST_ACK_DLM: if (bit_valid) begin
            if (rx_bit) begin
              state <= ST_EOF;
              cnt   <= '0;
            end else begin
              form_err <= 1'b1;
              state    <= ST_RECOVER;
            end
          end
          ST_EOF: if (bit_valid) begin
            if (cnt == CNT_W'(EOF_LEN - 1)) begin
              state <= ST_IDLE;
            end else if (!rx_bit) begin
              form_err <= 1'b1;
              state    <= ST_RECOVER;
            end else begin
              if (cnt == CNT_W'(EOF_LEN - 2)) begin
                frame_ok <= 1'b1;
                store_en <= id_hit;
              end
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/can_rx_errdet_sva.sv
module can_rx_errdet_sva (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic stuff_err,
  input logic form_err,
  input logic crc_err,
  input logic ack_drive,
  input logic frame_ok,
  input logic store_en
);

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stuff_err, form_err, crc_err, frame_ok})); // R12

  AST_EVENT_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_err || form_err || crc_err || frame_ok) |-> $past(bit_valid)); // R1

  AST_STORE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> frame_ok); // R10

  AST_ACK_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && bit_valid) |=> !ack_drive); // R9

  AST_NO_ACK_ON_CRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> !ack_drive); // R7

endmodule

bind can_rx_errdet can_rx_errdet_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .stuff_err (stuff_err),
  .form_err  (form_err),
  .crc_err   (crc_err),
  .ack_drive (ack_drive),
  .frame_ok  (frame_ok),
  .store_en  (store_en)
);

// File: tb/can_rx_errdet_tb.sv
`timescale 1ns/1ps
module can_rx_errdet_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bit_valid, bit_ready, rx_bit;
  logic [10:0] flt_id, flt_mask;
  logic stuff_err, form_err, crc_err, ack_drive, frame_ok, store_en;

  can_rx_errdet u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .rx_bit(rx_bit), .flt_id(flt_id), .flt_mask(flt_mask),
    .stuff_err(stuff_err), .form_err(form_err), .crc_err(crc_err),
    .ack_drive(ack_drive), .frame_ok(frame_ok), .store_en(store_en)
  );

  typedef struct packed {
    logic [10:0] id;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [2:0]  fault; // 0 none,1 crc flip,2 crc dlm,3 ack dlm,4 eof mid,5 eof last,6 stuff copy
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{11'h123, 1'b0, 4'd2,  64'hA55A_0000_0000_0000, 3'd0},
    '{11'h456, 1'b0, 4'd1,  64'h3C00_0000_0000_0000, 3'd0},
    '{11'h000, 1'b0, 4'd0,  64'h0,                   3'd6},
    '{11'h7FF, 1'b1, 4'd4,  64'h0,                   3'd0},
    '{11'h12F, 1'b0, 4'd15, 64'h0123_4567_89AB_CDEF, 3'd0},
    '{11'h120, 1'b0, 4'd3,  64'hFF00_FF00_0000_0000, 3'd1},
    '{11'h124, 1'b0, 4'd1,  64'h8100_0000_0000_0000, 3'd2},
    '{11'h125, 1'b0, 4'd2,  64'h0F0F_0000_0000_0000, 3'd3},
    '{11'h126, 1'b0, 4'd0,  64'h0,                   3'd4},
    '{11'h121, 1'b0, 4'd1,  64'h5500_0000_0000_0000, 3'd5},
    '{11'h000, 1'b0, 4'd0,  64'h0,                   3'd0}
  };

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic sbits [0:255];
  int   slen, stuff_pos, dlm_idx, ack_idx;
  int   ev_stuff, ev_form, ev_crc, ev_ok, ev_store;
  logic ack_at_slot, ack_after;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
    logic fb;
    fb = b ^ c[14];
    crc_step = {c[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0);
  endfunction

  task automatic clear_ev();
    ev_stuff = 0; ev_form = 0; ev_crc = 0; ev_ok = 0; ev_store = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    rx_bit    = b;
    @(negedge clk);
    bit_valid = 1'b0;
    rx_bit    = 1'b1;
    ev_stuff += int'(stuff_err);
    ev_form  += int'(form_err);
    ev_crc   += int'(crc_err);
    ev_ok    += int'(frame_ok);
    ev_store += int'(store_en);
  endtask

  task automatic build(input vec_t v);
    logic raw [0:127];
    int   rlen, nb, cnt;
    logic last;
    logic [14:0] c;
    rlen = 0;
    raw[rlen] = 1'b0; rlen++;
    for (int i = 10; i >= 0; i--) begin raw[rlen] = v.id[i]; rlen++; end
    raw[rlen] = v.rtr; rlen++;
    raw[rlen] = 1'b0; rlen++;
    raw[rlen] = 1'b0; rlen++;
    for (int i = 3; i >= 0; i--) begin raw[rlen] = v.dlc[i]; rlen++; end
    nb = v.rtr ? 0 : ((v.dlc > 8) ? 8 : int'(v.dlc));
    for (int i = 0; i < nb * 8; i++) begin raw[rlen] = v.data[63 - i]; rlen++; end
    c = '0;
    for (int i = 0; i < rlen; i++) c = crc_step(c, raw[i]);
    for (int i = 14; i >= 0; i--) begin raw[rlen] = c[i]; rlen++; end
    if (v.fault == 3'd1) raw[rlen - 1] = ~raw[rlen - 1];
    slen = 0; stuff_pos = -1; cnt = 0; last = 1'b1;
    for (int i = 0; i < rlen; i++) begin
      sbits[slen] = raw[i]; slen++;
      if (raw[i] == last) cnt++;
      else begin last = raw[i]; cnt = 1; end
      if (cnt == 5) begin
        if (stuff_pos < 0) stuff_pos = slen;
        sbits[slen] = ~raw[i]; slen++;
        last = ~raw[i]; cnt = 1;
      end
    end
    dlm_idx = slen;
    sbits[slen] = 1'b1; slen++;
    ack_idx = slen;
    sbits[slen] = 1'b0; slen++;
    sbits[slen] = (v.fault == 3'd3) ? 1'b0 : 1'b1; slen++;
    for (int i = 0; i < 7; i++) begin sbits[slen] = 1'b1; slen++; end
    if (v.fault == 3'd2) sbits[dlm_idx] = 1'b0;
    if (v.fault == 3'd4) sbits[ack_idx + 4] = 1'b0;
    if (v.fault == 3'd5) sbits[slen - 1] = 1'b0;
    if (v.fault == 3'd6 && stuff_pos > 0) sbits[stuff_pos] = sbits[stuff_pos - 1];
  endtask

  task automatic send_frame(input bit pad);
    clear_ev();
    ack_at_slot = 1'b0;
    ack_after   = 1'b0;
    for (int i = 0; i < slen; i++) begin
      if (i == ack_idx) ack_at_slot = ack_drive;
      send_bit(sbits[i]);
      if (i == ack_idx) ack_after = ack_drive;
      if (ev_stuff + ev_form + ev_crc != 0) break;
    end
    if (pad) for (int i = 0; i < 12; i++) send_bit(1'b1);
  endtask

  task automatic run_vec(input vec_t v, input int k);
    int  exp_ok, exp_form, exp_crc, exp_stuff, exp_store, exp_ack;
    logic [10:0] diff;
    build(v);
    send_frame(1'b1);
    exp_ok    = (v.fault == 3'd0 || v.fault == 3'd5) ? 1 : 0;
    exp_crc   = (v.fault == 3'd1) ? 1 : 0;
    exp_form  = (v.fault == 3'd2 || v.fault == 3'd3 || v.fault == 3'd4) ? 1 : 0;
    exp_stuff = (v.fault == 3'd6) ? 1 : 0;
    diff      = (v.id ^ flt_id) & flt_mask;
    exp_store = (exp_ok == 1 && diff == 11'h0) ? 1 : 0;
    exp_ack   = (v.fault == 3'd1 || v.fault == 3'd2 || v.fault == 3'd6) ? 0 : 1;
    // R2 R3 R13: frame alignment and data length give a clean frame
    chk($sformatf("R8 R6 frame_ok vec%0d", k), ev_ok, exp_ok);
    chk($sformatf("R7 crc_err vec%0d", k), ev_crc, exp_crc);
    chk($sformatf("R5 form_err vec%0d", k), ev_form, exp_form);
    chk($sformatf("R4 stuff_err vec%0d", k), ev_stuff, exp_stuff);
    chk($sformatf("R10 store_en vec%0d", k), ev_store, exp_store);
    chk($sformatf("R9 ack_drive in slot vec%0d", k), int'(ack_at_slot), exp_ack);
    if (exp_ack == 1) chk($sformatf("R9 ack_drive released vec%0d", k), int'(ack_after), 0);
  endtask

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; rx_bit = 1'b1;
    flt_id = 11'h123; flt_mask = 11'h7F0;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs quiet", int'({stuff_err, form_err, crc_err, ack_drive, frame_ok, store_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bit_ready high", int'(bit_ready), 1);

    // R1: level toggles with no valid transfer must be ignored
    clear_ev();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rx_bit = i[0];
      ev_stuff += int'(stuff_err); ev_form += int'(form_err);
      ev_crc += int'(crc_err); ev_ok += int'(frame_ok);
    end
    rx_bit = 1'b1;
    chk("R1 no events without valid", ev_stuff + ev_form + ev_crc + ev_ok, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R11: dominant levels after an error must not start a frame
    build(VECS[2]);
    send_frame(1'b0);
    chk("R4 stuff_err before recovery", ev_stuff, 1);
    clear_ev();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1);
    chk("R11 no events while recovering", ev_stuff + ev_form + ev_crc + ev_ok, 0);
    build(VECS[0]);
    send_frame(1'b1);
    chk("R11 frame after recovery valid", ev_ok, 1);

    // R10: all-zero mask accepts any identifier
    flt_mask = 11'h000;
    build(VECS[1]);
    send_frame(1'b1);
    chk("R10 open mask stores", ev_store, 1);
    chk("R8 open mask frame_ok", ev_ok, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule